// File: doc/BRIEF.md
# Rename Snapshot Queue Manager

This block decides when the rename stage takes a speculative-state snapshot and keeps track of up to four live snapshots in a small ring. Each slot holds the reorder-buffer index of the first micro-op that the snapshot covers. Other units store the actual payload, such as map tables and pointers. They follow the enqueue, dequeue, flush-vector and hit signals that this block drives, so every copy stays in step.

A rename group of up to six micro-ops asks for a snapshot when it contains a branch or jump. A group also asks for one when the running count of micro-ops since the last snapshot reaches 32. The request is merged onto the first micro-op of the group. Committing micro-ops retire the oldest snapshot once one of them carries that snapshot's index. On a redirect, the block drops every snapshot that is younger than the redirect point. It then reports the youngest surviving snapshot that can seed recovery, if one exists.

Top module: `snap_queue_mgr`

## Requirements
- R1: After reset the ring is empty. No enqueue, dequeue, flush or hit is signalled, and the first accepted snapshot goes to slot 0.
- R2: A group with at least one valid micro-op whose branch bit is set requests a snapshot. The merged flag vector then has only bit 0 set, and it is all zero when there is no request.
- R3: Without a branch, a group requests a snapshot when the micro-ops counted since the last snapshot, plus the valid micro-ops of this group, reach 32 or more. The count includes the boundary value of exactly 32.
- R4: The micro-op count restarts from zero whenever a snapshot is accepted and whenever a redirect is seen.
- R5: An accepted request writes the group's first reorder-buffer index into the slot named by the enqueue slot output, in ring order. No enqueue happens while all four slots are occupied.
- R6: A redirect in the same cycle cancels both an enqueue and a dequeue.
- R7: The head snapshot is dequeued, and its slot reported, when any valid one of the eight commit lanes carries an index equal to the head's recorded index. The head pointer then advances by one.
- R8: On a redirect, the flush-vector bit is set for each occupied slot whose index is strictly younger than the redirect index. Index bit 8 is the wrap flag and bits 7:0 are the position. Same flags compare positions directly, and differing flags invert the comparison. Flushed slots are empty from the next cycle.
- R9: On a redirect, a slot is a recovery candidate when its index is older than the redirect, or equal to it when the redirect does not flush its own instruction. The hit output reports the youngest candidate's slot, and it is low when there is no candidate.
- R10: After every update the enqueue slot becomes the first empty slot found by walking forward from the head slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ren_valid_i | input | 6 | Valid bit per micro-op of the rename group |
| ren_br_i | input | 6 | Branch or jump marker per micro-op |
| ren_rob_idx_i | input | 9 | Reorder-buffer index of the group's first micro-op (bit 8 wrap flag) |
| cmt_valid_i | input | 8 | Valid bit per commit lane |
| cmt_rob_idx_i | input | 8x9 | Reorder-buffer index per commit lane |
| redir_valid_i | input | 1 | Redirect present this cycle |
| redir_rob_idx_i | input | 9 | Reorder-buffer index of the redirecting instruction |
| redir_flush_self_i | input | 1 | Redirect also discards its own instruction |
| snap_flag_o | output | 6 | Merged snapshot flag per micro-op (only bit 0 can be set) |
| snap_enq_o | output | 1 | Snapshot accepted this cycle |
| snap_enq_slot_o | output | 2 | Slot receiving the snapshot |
| snap_deq_o | output | 1 | Head snapshot retired this cycle |
| snap_deq_slot_o | output | 2 | Slot being retired |
| snap_flush_vec_o | output | 4 | Slots discarded by the current redirect |
| snap_hit_o | output | 1 | A snapshot is usable for recovery |
| snap_hit_slot_o | output | 2 | Slot to recover from |

## Verification
The properties assume two things about the inputs. First, the commit and redirect indices come from the same wrapping index space as the stored snapshots. Second, live snapshot indices never span more than one wrap of the reorder buffer, so the flag-and-position comparison stays unambiguous. The stimulus keeps every stored index within a window shorter than the buffer depth. Only one scenario crosses the wrap boundary, and it does so with two snapshots on opposite flags. Commits and redirects are only ever driven with indices that either match a live snapshot exactly or lie clearly before or after it.

// File: rtl/snapq_pkg.sv
package snapq_pkg;

  // a strictly younger than b; flag bit toggles on each ring wrap
  function automatic logic idx_newer(input logic fa, input logic [31:0] va,
                                     input logic fb, input logic [31:0] vb);
    return (fa == fb) ? (va > vb) : (va < vb);
  endfunction

endpackage

// File: rtl/snapq_req_gen.sv
module snapq_req_gen #(
  parameter int unsigned RENAME_W = 6,
  parameter int unsigned PERIOD   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [RENAME_W-1:0] ren_valid_i,
  input  logic [RENAME_W-1:0] ren_br_i,
  input  logic                take_i,
  input  logic                redir_i,
  output logic                req_o,
  output logic [RENAME_W-1:0] flag_o
);
  localparam int unsigned SUM_W = $clog2(PERIOD + RENAME_W + 1);
  localparam int unsigned N_W   = $clog2(RENAME_W + 1);

  logic [SUM_W-1:0] cnt_q, cnt_d, sum;
  logic [N_W-1:0]   n_uop;
  logic             periodic, any_br, any_v;

  always_comb begin
    n_uop = '0;
    for (int i = 0; i < RENAME_W; i++) n_uop = n_uop + N_W'(ren_valid_i[i]);
  end

  assign sum      = cnt_q + SUM_W'(n_uop);
  assign periodic = (sum >= SUM_W'(PERIOD));
  assign any_br   = |(ren_valid_i & ren_br_i);
  assign any_v    = |ren_valid_i;
  assign req_o    = any_v && (any_br || periodic);

  // all per-uop requests collapse onto lane 0
  always_comb begin
    flag_o    = '0;
    flag_o[0] = req_o;
  end

  always_comb begin
    if (redir_i || take_i) cnt_d = '0;
    else if (periodic)     cnt_d = SUM_W'(PERIOD);
    else                   cnt_d = sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/snapq_store.sv
module snapq_store #(
  parameter int unsigned NUM_SNAP = 4,
  parameter int unsigned IDX_W    = 9
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               enq_i,
  input  logic [IDX_W-1:0]                   enq_idx_i,
  input  logic                               deq_i,
  input  logic [NUM_SNAP-1:0]                flush_vec_i,
  output logic [NUM_SNAP-1:0]                valid_o,
  output logic [NUM_SNAP-1:0][IDX_W-1:0]     idx_o,
  output logic [$clog2(NUM_SNAP)-1:0]        enq_ptr_o,
  output logic [$clog2(NUM_SNAP)-1:0]        deq_ptr_o,
  output logic                               full_o
);
  localparam int unsigned SLOT_W = $clog2(NUM_SNAP);

  logic [NUM_SNAP-1:0]            valid_q, valid_d;
  logic [NUM_SNAP-1:0][IDX_W-1:0] idx_q;
  logic [SLOT_W-1:0]              enq_ptr_q, enq_ptr_d, deq_ptr_q, deq_ptr_d;

  always_comb begin
    valid_d = valid_q & ~flush_vec_i;
    if (enq_i) valid_d[enq_ptr_q] = 1'b1;
    if (deq_i) valid_d[deq_ptr_q] = 1'b0;
  end

  assign deq_ptr_d = deq_i ? deq_ptr_q + SLOT_W'(1) : deq_ptr_q;

  // nearest empty slot walking forward from the head
  always_comb begin
    enq_ptr_d = enq_ptr_q;
    for (int k = NUM_SNAP - 1; k >= 0; k--) begin
      if (!valid_d[deq_ptr_d + SLOT_W'(k)]) enq_ptr_d = deq_ptr_d + SLOT_W'(k);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= '0;
      enq_ptr_q <= '0;
      deq_ptr_q <= '0;
    end else begin
      valid_q   <= valid_d;
      enq_ptr_q <= enq_ptr_d;
      deq_ptr_q <= deq_ptr_d;
    end
  end

  generate
    for (genvar s = 0; s < NUM_SNAP; s++) begin : g_slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                 idx_q[s] <= '0;
        else if (enq_i && enq_ptr_q == SLOT_W'(s))   idx_q[s] <= enq_idx_i;
      end
    end
  endgenerate

  assign valid_o   = valid_q;
  assign idx_o     = idx_q;
  assign enq_ptr_o = enq_ptr_q;
  assign deq_ptr_o = deq_ptr_q;
  assign full_o    = &valid_q;
endmodule

// File: rtl/snapq_redir.sv
module snapq_redir
  import snapq_pkg::*;
#(
  parameter int unsigned NUM_SNAP = 4,
  parameter int unsigned IDX_W    = 9
) (
  input  logic                           redir_valid_i,
  input  logic [IDX_W-1:0]               redir_idx_i,
  input  logic                           flush_self_i,
  input  logic [NUM_SNAP-1:0]            valid_i,
  input  logic [NUM_SNAP-1:0][IDX_W-1:0] idx_i,
  input  logic [$clog2(NUM_SNAP)-1:0]    deq_ptr_i,
  output logic [NUM_SNAP-1:0]            flush_vec_o,
  output logic                           hit_o,
  output logic [$clog2(NUM_SNAP)-1:0]    hit_slot_o
);
  localparam int unsigned SLOT_W = $clog2(NUM_SNAP);
  localparam int unsigned LOW_W  = IDX_W - 1;

  logic [NUM_SNAP-1:0] younger, same, cand;

  generate
    for (genvar s = 0; s < NUM_SNAP; s++) begin : g_cmp
      assign younger[s] = idx_newer(idx_i[s][IDX_W-1], 32'(idx_i[s][LOW_W-1:0]),
                                    redir_idx_i[IDX_W-1], 32'(redir_idx_i[LOW_W-1:0]));
      assign same[s]    = (idx_i[s] == redir_idx_i);
      assign flush_vec_o[s] = redir_valid_i && valid_i[s] && younger[s];
      assign cand[s]    = redir_valid_i && valid_i[s] && !younger[s]
                          && (!same[s] || !flush_self_i);
    end
  endgenerate

  // ring order from head is age order; last candidate is youngest
  always_comb begin
    hit_o      = 1'b0;
    hit_slot_o = '0;
    for (int k = 0; k < NUM_SNAP; k++) begin
      if (cand[deq_ptr_i + SLOT_W'(k)]) begin
        hit_o      = 1'b1;
        hit_slot_o = deq_ptr_i + SLOT_W'(k);
      end
    end
  end
endmodule

// File: rtl/snap_queue_mgr.sv
module snap_queue_mgr #(
  parameter int unsigned NUM_SNAP  = 4,
  parameter int unsigned RENAME_W  = 6,
  parameter int unsigned COMMIT_W  = 8,
  parameter int unsigned ROB_DEPTH = 160,
  parameter int unsigned PERIOD    = 32,
  localparam int unsigned IDX_W    = $clog2(ROB_DEPTH) + 1,
  localparam int unsigned SLOT_W   = $clog2(NUM_SNAP)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [RENAME_W-1:0]            ren_valid_i,
  input  logic [RENAME_W-1:0]            ren_br_i,
  input  logic [IDX_W-1:0]               ren_rob_idx_i,
  input  logic [COMMIT_W-1:0]            cmt_valid_i,
  input  logic [COMMIT_W-1:0][IDX_W-1:0] cmt_rob_idx_i,
  input  logic                           redir_valid_i,
  input  logic [IDX_W-1:0]               redir_rob_idx_i,
  input  logic                           redir_flush_self_i,
  output logic [RENAME_W-1:0]            snap_flag_o,
  output logic                           snap_enq_o,
  output logic [SLOT_W-1:0]              snap_enq_slot_o,
  output logic                           snap_deq_o,
  output logic [SLOT_W-1:0]              snap_deq_slot_o,
  output logic [NUM_SNAP-1:0]            snap_flush_vec_o,
  output logic                           snap_hit_o,
  output logic [SLOT_W-1:0]              snap_hit_slot_o
);
  logic                           req, full;
  logic [NUM_SNAP-1:0]            slot_valid;
  logic [NUM_SNAP-1:0][IDX_W-1:0] slot_idx;
  logic [SLOT_W-1:0]              enq_ptr, deq_ptr;
  logic [COMMIT_W-1:0]            lane_match;

  snapq_req_gen #(.RENAME_W(RENAME_W), .PERIOD(PERIOD)) u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ren_valid_i (ren_valid_i),
    .ren_br_i    (ren_br_i),
    .take_i      (snap_enq_o),
    .redir_i     (redir_valid_i),
    .req_o       (req),
    .flag_o      (snap_flag_o)
  );

  generate
    for (genvar j = 0; j < COMMIT_W; j++) begin : g_lane
      assign lane_match[j] = cmt_valid_i[j] && (cmt_rob_idx_i[j] == slot_idx[deq_ptr]);
    end
  endgenerate

  assign snap_enq_o      = req && !full && !redir_valid_i;
  assign snap_enq_slot_o = enq_ptr;
  assign snap_deq_o      = slot_valid[deq_ptr] && (|lane_match) && !redir_valid_i;
  assign snap_deq_slot_o = deq_ptr;

  snapq_store #(.NUM_SNAP(NUM_SNAP), .IDX_W(IDX_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enq_i       (snap_enq_o),
    .enq_idx_i   (ren_rob_idx_i),
    .deq_i       (snap_deq_o),
    .flush_vec_i (snap_flush_vec_o),
    .valid_o     (slot_valid),
    .idx_o       (slot_idx),
    .enq_ptr_o   (enq_ptr),
    .deq_ptr_o   (deq_ptr),
    .full_o      (full)
  );

  snapq_redir #(.NUM_SNAP(NUM_SNAP), .IDX_W(IDX_W)) u_redir (
    .redir_valid_i (redir_valid_i),
    .redir_idx_i   (redir_rob_idx_i),
    .flush_self_i  (redir_flush_self_i),
    .valid_i       (slot_valid),
    .idx_i         (slot_idx),
    .deq_ptr_i     (deq_ptr),
    .flush_vec_o   (snap_flush_vec_o),
    .hit_o         (snap_hit_o),
    .hit_slot_o    (snap_hit_slot_o)
  );
endmodule

// File: rtl/snap_queue_chk.sv
module snap_queue_chk #(
  parameter int unsigned NUM_SNAP = 4,
  parameter int unsigned RENAME_W = 6,
  parameter int unsigned SLOT_W   = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [RENAME_W-1:0] ren_valid_i,
  input logic [RENAME_W-1:0] ren_br_i,
  input logic                redir_valid_i,
  input logic [RENAME_W-1:0] snap_flag_o,
  input logic                snap_enq_o,
  input logic [SLOT_W-1:0]   snap_enq_slot_o,
  input logic                snap_deq_o,
  input logic [SLOT_W-1:0]   snap_deq_slot_o,
  input logic [NUM_SNAP-1:0] snap_flush_vec_o,
  input logic                snap_hit_o,
  input logic [SLOT_W-1:0]   snap_hit_slot_o,
  input logic [NUM_SNAP-1:0] slot_valid_i
);
  // R2
  br_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ren_valid_i & ren_br_i)) |-> snap_flag_o[0]);

  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_enq_o |-> !(&slot_valid_i));

  // R5
  enq_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_enq_o |=> slot_valid_i[$past(snap_enq_slot_o)]);

  // R6
  redir_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_valid_i |-> (!snap_enq_o && !snap_deq_o));

  // R7
  deq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_deq_o |=> !slot_valid_i[$past(snap_deq_slot_o)]);

  // R8
  quiet_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !redir_valid_i |-> (snap_flush_vec_o == '0 && !snap_hit_o));

  // R9
  hit_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_hit_o |-> (slot_valid_i[snap_hit_slot_o] && !snap_flush_vec_o[snap_hit_slot_o]));
endmodule

bind snap_queue_mgr snap_queue_chk #(
  .NUM_SNAP(NUM_SNAP), .RENAME_W(RENAME_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .ren_valid_i      (ren_valid_i),
  .ren_br_i         (ren_br_i),
  .redir_valid_i    (redir_valid_i),
  .snap_flag_o      (snap_flag_o),
  .snap_enq_o       (snap_enq_o),
  .snap_enq_slot_o  (snap_enq_slot_o),
  .snap_deq_o       (snap_deq_o),
  .snap_deq_slot_o  (snap_deq_slot_o),
  .snap_flush_vec_o (snap_flush_vec_o),
  .snap_hit_o       (snap_hit_o),
  .snap_hit_slot_o  (snap_hit_slot_o),
  .slot_valid_i     (slot_valid)
);

// File: tb/snap_queue_mgr_test.sv
`timescale 1ns/1ps
module snap_queue_mgr_test;
  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [5:0]       ren_valid_i, ren_br_i;
  logic [8:0]       ren_rob_idx_i;
  logic [7:0]       cmt_valid_i;
  logic [7:0][8:0]  cmt_rob_idx_i;
  logic             redir_valid_i, redir_flush_self_i;
  logic [8:0]       redir_rob_idx_i;
  logic [5:0]       snap_flag_o;
  logic             snap_enq_o, snap_deq_o, snap_hit_o;
  logic [1:0]       snap_enq_slot_o, snap_deq_slot_o, snap_hit_slot_o;
  logic [3:0]       snap_flush_vec_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  snap_queue_mgr uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    ren_valid_i = '0; ren_br_i = '0; ren_rob_idx_i = '0;
    cmt_valid_i = '0; cmt_rob_idx_i = '0;
    redir_valid_i = 1'b0; redir_rob_idx_i = '0; redir_flush_self_i = 1'b0;
  endtask

  task automatic step();
    @(negedge clk_i);
    idle();
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    idle();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic group(input int n, input bit br, input logic [8:0] idx);
    ren_valid_i   = 6'((1 << n) - 1);
    ren_br_i      = br ? 6'b000100 : 6'b0;
    ren_rob_idx_i = idx;
  endtask

  task automatic redir(input logic [8:0] idx, input bit self_f);
    redir_valid_i = 1'b1; redir_rob_idx_i = idx; redir_flush_self_i = self_f;
  endtask

  task automatic t_branch();
    do_reset();
    #1;
    chk("R1 enq", snap_enq_o, 0);
    chk("R1 deq", snap_deq_o, 0);
    chk("R1 hit", snap_hit_o, 0);
    chk("R1 flush", snap_flush_vec_o, 0);
    group(6, 1, 9'd10); #1;
    chk("R2 merged flag", snap_flag_o, 6'b000001);
    chk("R1 first slot", snap_enq_slot_o, 0);
    chk("R5 enq", snap_enq_o, 1);
    step();
    group(6, 0, 9'd16); #1;
    chk("R2 no branch flag", snap_flag_o, 0);
    step();
    for (int i = 1; i < 4; i++) begin
      group(3, 1, 9'(10 + 10 * i)); #1;
      chk("R5 ring slot", snap_enq_slot_o, i);
      chk("R5 enq", snap_enq_o, 1);
      step();
    end
    group(6, 1, 9'd60); #1;
    chk("R2 flag when full", snap_flag_o[0], 1);
    chk("R5 full blocks", snap_enq_o, 0);
    step();
  endtask

  task automatic t_period();
    do_reset();
    for (int g = 0; g < 7; g++) begin
      group(4, 0, 9'd0); #1;
      chk("R3 below period", snap_flag_o[0], 0);
      step();
    end
    group(4, 0, 9'd0); #1;
    chk("R3 exactly 32", snap_flag_o[0], 1);
    chk("R3 enq slot", snap_enq_slot_o, 0);
    step();
    for (int g = 0; g < 7; g++) begin
      group(4, 0, 9'd1); #1;
      chk("R4 count restart after snapshot", snap_flag_o[0], 0);
      step();
    end
    group(4, 0, 9'd1); #1;
    chk("R4 period again", snap_flag_o[0], 1);
    chk("R4 enq slot", snap_enq_slot_o, 1);
    step();
    for (int g = 0; g < 4; g++) begin
      group(4, 0, 9'd2);
      step();
    end
    redir(9'd150, 0); #1;
    chk("R8 no younger", snap_flush_vec_o, 0);
    step();
    for (int g = 0; g < 7; g++) begin
      group(4, 0, 9'd3); #1;
      chk("R4 count restart after redirect", snap_flag_o[0], 0);
      step();
    end
    group(4, 0, 9'd3); #1;
    chk("R4 period after redirect", snap_flag_o[0], 1);
    step();
  endtask

  task automatic t_deq();
    do_reset();
    group(6, 1, 9'd10); step();
    group(6, 1, 9'd20); step();
    cmt_valid_i = 8'hFF;
    for (int j = 0; j < 8; j++) cmt_rob_idx_i[j] = 9'(j);
    #1;
    chk("R7 no match", snap_deq_o, 0);
    step();
    cmt_valid_i[5] = 1'b1; cmt_rob_idx_i[5] = 9'd10;
    cmt_valid_i[2] = 1'b1; cmt_rob_idx_i[2] = 9'd11;
    #1;
    chk("R7 match deq", snap_deq_o, 1);
    chk("R7 deq slot", snap_deq_slot_o, 0);
    step();
    cmt_valid_i[7] = 1'b1; cmt_rob_idx_i[7] = 9'd20;
    group(6, 1, 9'd30);
    redir(9'd100, 1); #1;
    chk("R6 deq cancelled", snap_deq_o, 0);
    chk("R6 enq cancelled", snap_enq_o, 0);
    chk("R9 hit", snap_hit_o, 1);
    chk("R9 hit slot", snap_hit_slot_o, 1);
    step();
    cmt_valid_i[0] = 1'b1; cmt_rob_idx_i[0] = 9'd20; #1;
    chk("R7 head advanced", snap_deq_o, 1);
    chk("R7 head slot", snap_deq_slot_o, 1);
    step();
    cmt_valid_i[0] = 1'b0; cmt_rob_idx_i[0] = 9'd20; #1;
    chk("R7 invalid lane", snap_deq_o, 0);
    step();
  endtask

  task automatic t_flush();
    do_reset();
    group(6, 1, 9'd10);  step();
    group(6, 1, 9'd50);  step();
    group(6, 1, 9'd90);  step();
    group(6, 1, 9'd130); step();
    redir(9'd60, 1); #1;
    chk("R8 flush vec", snap_flush_vec_o, 4'b1100);
    chk("R9 youngest older", snap_hit_slot_o, 1);
    step();
    group(6, 1, 9'd70); #1;
    chk("R10 enq slot after flush", snap_enq_slot_o, 2);
    step();
    redir(9'd70, 1); #1;
    chk("R8 equal kept", snap_flush_vec_o, 0);
    chk("R9 equal excluded", snap_hit_slot_o, 1);
    step();
    redir(9'd70, 0); #1;
    chk("R9 equal allowed", snap_hit_slot_o, 2);
    step();
    // wrap: flag bit differs
    do_reset();
    group(6, 1, {1'b0, 8'd150}); step();
    group(6, 1, {1'b1, 8'd5});   step();
    redir({1'b1, 8'd2}, 1); #1;
    chk("R8 wrap flush", snap_flush_vec_o, 4'b0010);
    chk("R9 wrap hit", snap_hit_o, 1);
    chk("R9 wrap hit slot", snap_hit_slot_o, 0);
    step();
    // head not at slot 0
    do_reset();
    group(6, 1, 9'd10); step();
    group(6, 1, 9'd20); step();
    group(6, 1, 9'd30); step();
    cmt_valid_i[3] = 1'b1; cmt_rob_idx_i[3] = 9'd10; step();
    redir(9'd15, 1); #1;
    chk("R8 flush after head", snap_flush_vec_o, 4'b0110);
    chk("R9 no candidate", snap_hit_o, 0);
    step();
    group(6, 1, 9'd16); #1;
    chk("R10 nearest to head", snap_enq_slot_o, 1);
    step();
  endtask

  initial begin
    idle();
    t_branch();
    t_period();
    t_deq();
    t_flush();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule